// File: doc/BRIEF.md
# Trace Commit Depth Predictor

This block predicts how far a freshly selected trace will get before a rollback. Once the next trace has been chosen, the frontend presents that trace's internal entry point. One cycle later the block answers with a 4-bit depth: the number of commit points the trace is expected to pass. After the trace finishes, the frontend trains the same entry with the depth actually reached. The next prediction for that trace is therefore the last outcome seen.

The storage is a 1024-entry, 2-way set-associative table. Each way holds a valid bit, a tag and the depth. On a miss the answer is the all-ones depth, which means the whole trace is expected to commit. A small state machine uses the response to steer fetch. It counts the marked commit-point instructions as they enter the pipeline. One cycle after the predicted one, it pulses a redirect to the alternate trace. If the expected rollback never comes and the current trace's fetch queue drains, it holds a fixed-length flush penalty. It then stays on the current trace until that trace ends.

The state machine has six states:
- IDLE: no trace is being steered.
- FOLLOW: the block is counting commit marks.
- REDIR: one cycle in which the redirect is driven.
- ALT: fetch is on the alternate trace, waiting for the rollback.
- FLUSH: the penalty window.
- DRAIN: the block is back on the current trace, waiting for its end.

The transitions are:
- A lookup response from any state starts a trace. It enters REDIR if the depth is 0, and FOLLOW otherwise.
- FOLLOW goes to REDIR on the predicted mark. It goes to IDLE on trace end.
- REDIR and ALT go to IDLE on rollback, to FLUSH on an empty fetch queue without rollback, and otherwise to ALT.
- FLUSH goes to DRAIN after its window.
- DRAIN goes to IDLE on trace end.

Top module: `trace_depth_predictor`

## Requirements
- R1: A lookup request is answered by `lk_rsp_vld` high in exactly the next cycle, and only then.
- R2: A lookup that matches no valid way returns hit 0 and depth 4'b1111.
- R3: Training writes the given depth into the matching way, so a later lookup of that entry point returns the most recently trained depth.
- R4: Entry-point bits [8:0] select the set and bits [15:9] form the tag. Training one set never changes a lookup result in another set.
- R5: A training miss fills way 0 if it is invalid, then way 1 if it is invalid. Otherwise it replaces the way not written by the most recent training of that set.
- R6: When training and lookup target the same set in the same cycle, the response reflects the training write.
- R7: With a predicted depth n from 1 to 14, `redirect` is high for exactly one cycle. That cycle is the one after the clock edge that samples the n-th `cp_mark` since the response. With depth 0, `redirect` is high in the cycle after the edge that consumes the response.
- R8: A predicted depth of 4'b1111 never raises `redirect`, however many marks arrive.
- R9: After a redirect, `fq_empty` without `rollback` raises `flush_busy` for exactly FLUSH_CYC (5) consecutive cycles.
- R10: A `rollback` after the redirect returns the block to IDLE. A later `fq_empty` causes no flush.
- R11: Out of reset, `lk_rsp_vld`, `redirect` and `flush_busy` are low and every table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request for the selected trace |
| lk_ep | input | 16 | Entry point of the selected trace |
| lk_rsp_vld | output | 1 | Lookup response valid |
| lk_rsp_hit | output | 1 | Entry point was found |
| lk_rsp_depth | output | 4 | Predicted commit depth |
| tr_vld | input | 1 | Training write |
| tr_ep | input | 16 | Entry point being trained |
| tr_depth | input | 4 | Commit points actually passed |
| cp_mark | input | 1 | Commit-point instruction entered the pipeline |
| rollback | input | 1 | Predicted rollback happened |
| fq_empty | input | 1 | Current-trace fetch queue is empty |
| trace_done | input | 1 | Current trace finished |
| redirect | output | 1 | Switch fetch to the alternate trace |
| flush_busy | output | 1 | Frontend flush penalty in progress |

## Verification
The bench fills a set, refreshes one way and then forces an eviction. A design that tracked recency wrongly would evict the freshly trained entry rather than the stale one. It also trains and looks up the same entry point in one cycle. A read-first table would report a miss there.

For the fetch side, it checks that the redirect lands exactly one cycle after the n-th mark. An off-by-one counter would fire a mark early or late. It also covers a zero depth, which a counter-only design would never redirect. An all-ones depth must never redirect, even after fifteen marks.

Finally, it measures the flush window length. It also checks that a rollback suppresses the flush, which a design ignoring the rollback would still charge.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FOLLOW,
        ST_REDIR,
        ST_ALT,
        ST_FLUSH,
        ST_DRAIN
    } tdp_state_e;
endpackage

// File: rtl/tdp_table.sv
module tdp_table #(
    parameter int SETS    = 512,
    parameter int IDX_W   = 9,
    parameter int TAG_W   = 7,
    parameter int EP_W    = 16,
    parameter int DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_req,
    input  logic [EP_W-1:0]    lk_ep,
    output logic               rsp_vld,
    output logic               rsp_hit,
    output logic [DEPTH_W-1:0] rsp_depth,
    input  logic               tr_vld,
    input  logic [EP_W-1:0]    tr_ep,
    input  logic [DEPTH_W-1:0] tr_depth
);
    localparam int WAYS = 2;

    typedef struct packed {
        logic               vld;
        logic [TAG_W-1:0]   tag;
        logic [DEPTH_W-1:0] depth;
    } ent_t;

    ent_t            mem [SETS][WAYS];
    logic [SETS-1:0] lru;   // way to replace next

    logic [IDX_W-1:0] lk_set, tr_set;
    logic [TAG_W-1:0] lk_tag, tr_tag;
    assign lk_set = lk_ep[IDX_W-1:0];
    assign lk_tag = lk_ep[EP_W-1:IDX_W];
    assign tr_set = tr_ep[IDX_W-1:0];
    assign tr_tag = tr_ep[EP_W-1:IDX_W];

    logic [WAYS-1:0] tr_hit_v, lk_hit_v;
    ent_t            rd_ent [WAYS];
    ent_t            new_ent;
    logic            tr_way;

    assign new_ent = '{vld: 1'b1, tag: tr_tag, depth: tr_depth};

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign tr_hit_v[w] = mem[tr_set][w].vld && (mem[tr_set][w].tag == tr_tag);
        // write-first view of the looked-up set
        assign rd_ent[w] = (tr_vld && (tr_set == lk_set) && (tr_way == 1'(w)))
                           ? new_ent : mem[lk_set][w];
        assign lk_hit_v[w] = rd_ent[w].vld && (rd_ent[w].tag == lk_tag);
    end

    always_comb begin
        if (tr_hit_v[0])               tr_way = 1'b0;
        else if (tr_hit_v[1])          tr_way = 1'b1;
        else if (!mem[tr_set][0].vld)  tr_way = 1'b0;
        else if (!mem[tr_set][1].vld)  tr_way = 1'b1;
        else                           tr_way = lru[tr_set];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld   <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_depth <= '0;
            lru       <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    mem[s][w].vld <= 1'b0;
                end
            end
        end else begin
            rsp_vld <= lk_req;
            if (lk_req) begin
                rsp_hit <= |lk_hit_v;
                if (lk_hit_v[0])      rsp_depth <= rd_ent[0].depth;
                else if (lk_hit_v[1]) rsp_depth <= rd_ent[1].depth;
                else                  rsp_depth <= '1;
            end
            if (tr_vld) begin
                mem[tr_set][tr_way] <= new_ent;
                lru[tr_set]         <= ~tr_way;
            end
        end
    end
endmodule

// File: rtl/tdp_fetch_fsm.sv
module tdp_fetch_fsm
    import tdp_pkg::*;
#(
    parameter int DEPTH_W   = 4,
    parameter int FLUSH_CYC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DEPTH_W-1:0] start_depth,
    input  logic               cp_mark,
    input  logic               rollback,
    input  logic               fq_empty,
    input  logic               trace_done,
    output logic               redirect,
    output logic               flush_busy
);
    localparam int                 FC_W  = $clog2(FLUSH_CYC + 1);
    localparam logic [FC_W-1:0]    FLAST = FC_W'(FLUSH_CYC - 1);
    localparam logic [DEPTH_W-1:0] ONE   = DEPTH_W'(1);
    localparam logic [DEPTH_W-1:0] FULL  = '1;

    tdp_state_e         state, nxt;
    logic [DEPTH_W-1:0] pred, seen, seen_inc;
    logic [FC_W-1:0]    fcnt;

    assign seen_inc = seen + ONE;

    always_comb begin
        nxt = state;
        if (start) begin
            nxt = (start_depth == '0) ? ST_REDIR : ST_FOLLOW;
        end else begin
            unique case (state)
                ST_IDLE:   nxt = ST_IDLE;
                ST_FOLLOW: begin
                    if (trace_done) nxt = ST_IDLE;
                    else if (cp_mark && (pred != FULL) && (seen_inc == pred)) nxt = ST_REDIR;
                end
                ST_REDIR, ST_ALT: begin
                    if (rollback)      nxt = ST_IDLE;
                    else if (fq_empty) nxt = ST_FLUSH;
                    else               nxt = ST_ALT;
                end
                ST_FLUSH:  if (fcnt == FLAST) nxt = ST_DRAIN;
                ST_DRAIN:  if (trace_done) nxt = ST_IDLE;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pred  <= '0;
            seen  <= '0;
            fcnt  <= '0;
        end else begin
            state <= nxt;
            if (start) begin
                pred <= start_depth;
                seen <= '0;
            end else if (state == ST_FOLLOW && cp_mark) begin
                seen <= seen_inc;
            end
            if (state != ST_FLUSH) fcnt <= '0;
            else                   fcnt <= fcnt + FC_W'(1);
        end
    end

    always_comb begin
        redirect   = 1'b0;
        flush_busy = 1'b0;
        unique case (state)
            ST_REDIR: redirect   = 1'b1;
            ST_FLUSH: flush_busy = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/trace_depth_predictor.sv
module trace_depth_predictor #(
    parameter int ENTRIES   = 1024,
    parameter int EP_W      = 16,
    parameter int DEPTH_W   = 4,
    parameter int FLUSH_CYC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_req,
    input  logic [EP_W-1:0]    lk_ep,
    output logic               lk_rsp_vld,
    output logic               lk_rsp_hit,
    output logic [DEPTH_W-1:0] lk_rsp_depth,
    input  logic               tr_vld,
    input  logic [EP_W-1:0]    tr_ep,
    input  logic [DEPTH_W-1:0] tr_depth,
    input  logic               cp_mark,
    input  logic               rollback,
    input  logic               fq_empty,
    input  logic               trace_done,
    output logic               redirect,
    output logic               flush_busy
);
    localparam int SETS  = ENTRIES / 2;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = EP_W - IDX_W;

    tdp_table #(
        .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .EP_W(EP_W), .DEPTH_W(DEPTH_W)
    ) table_i (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_ep(lk_ep),
        .rsp_vld(lk_rsp_vld), .rsp_hit(lk_rsp_hit), .rsp_depth(lk_rsp_depth),
        .tr_vld(tr_vld), .tr_ep(tr_ep), .tr_depth(tr_depth)
    );

    tdp_fetch_fsm #(
        .DEPTH_W(DEPTH_W), .FLUSH_CYC(FLUSH_CYC)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .start(lk_rsp_vld), .start_depth(lk_rsp_depth),
        .cp_mark(cp_mark), .rollback(rollback), .fq_empty(fq_empty),
        .trace_done(trace_done),
        .redirect(redirect), .flush_busy(flush_busy)
    );
endmodule

// File: rtl/tdp_checker.sv
module tdp_checker #(
    parameter int DEPTH_W   = 4,
    parameter int FLUSH_CYC = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_req,
    input logic               lk_rsp_vld,
    input logic               lk_rsp_hit,
    input logic [DEPTH_W-1:0] lk_rsp_depth,
    input logic               rollback,
    input logic               fq_empty,
    input logic               redirect,
    input logic               flush_busy
);
    int flen;

    always_ff @(posedge clk) begin
        if (!rst_n)          flen <= 0;
        else if (flush_busy) flen <= flen + 1;
        else                 flen <= 0;
    end

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_rsp_vld); // R1
    AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_rsp_vld); // R1
    AST_MISS_FULL_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_rsp_vld && !lk_rsp_hit) |-> (lk_rsp_depth == '1)); // R2
    AST_REDIR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect); // R7
    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_busy) |-> ($past(fq_empty) && !$past(rollback))); // R9
    AST_FLUSH_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_busy) |-> (flen == FLUSH_CYC)); // R9
    AST_FLUSH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        flen <= FLUSH_CYC); // R9
    AST_NO_REDIR_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !(redirect && flush_busy)); // R7
endmodule

bind trace_depth_predictor tdp_checker #(
    .DEPTH_W(DEPTH_W), .FLUSH_CYC(FLUSH_CYC)
) chk_i (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_rsp_vld(lk_rsp_vld),
    .lk_rsp_hit(lk_rsp_hit), .lk_rsp_depth(lk_rsp_depth), .rollback(rollback),
    .fq_empty(fq_empty), .redirect(redirect), .flush_busy(flush_busy)
);

// File: tb/trace_depth_predictor_tb_top.sv
module trace_depth_predictor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0, tr_vld = 1'b0;
    logic [15:0] lk_ep = '0, tr_ep = '0;
    logic [3:0]  tr_depth = '0;
    logic        cp_mark = 1'b0, rollback = 1'b0, fq_empty = 1'b0, trace_done = 1'b0;
    logic        lk_rsp_vld, lk_rsp_hit, redirect, flush_busy;
    logic [3:0]  lk_rsp_depth;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    trace_depth_predictor dut_i (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_ep(lk_ep),
        .lk_rsp_vld(lk_rsp_vld), .lk_rsp_hit(lk_rsp_hit), .lk_rsp_depth(lk_rsp_depth),
        .tr_vld(tr_vld), .tr_ep(tr_ep), .tr_depth(tr_depth),
        .cp_mark(cp_mark), .rollback(rollback), .fq_empty(fq_empty),
        .trace_done(trace_done), .redirect(redirect), .flush_busy(flush_busy)
    );

    // entry point = {tag[6:0], set[8:0]}
    localparam logic [15:0] EP_A = 16'h0205; // set 5, tag 1
    localparam logic [15:0] EP_B = 16'h0405; // set 5, tag 2
    localparam logic [15:0] EP_C = 16'h0605; // set 5, tag 3
    localparam logic [15:0] EP_D = 16'h0206; // set 6, tag 1

    // {kind(1=lookup), ep, depth, exp_hit, exp_depth}
    localparam int NV = 16;
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, EP_A, 4'd0, 1'b0, 4'd15},  // R2 cold miss
        {1'b0, EP_A, 4'd3, 1'b0, 4'd0},
        {1'b1, EP_A, 4'd0, 1'b1, 4'd3},   // R3
        {1'b0, EP_B, 4'd7, 1'b0, 4'd0},   // R5 fills way 1
        {1'b1, EP_B, 4'd0, 1'b1, 4'd7},
        {1'b1, EP_A, 4'd0, 1'b1, 4'd3},
        {1'b0, EP_A, 4'd9, 1'b0, 4'd0},   // R3 overwrite
        {1'b1, EP_A, 4'd0, 1'b1, 4'd9},
        {1'b0, EP_C, 4'd2, 1'b0, 4'd0},   // R5 evicts B
        {1'b1, EP_B, 4'd0, 1'b0, 4'd15},
        {1'b1, EP_C, 4'd0, 1'b1, 4'd2},
        {1'b1, EP_A, 4'd0, 1'b1, 4'd9},
        {1'b1, EP_D, 4'd0, 1'b0, 4'd15},  // R4 other set
        {1'b0, EP_D, 4'd4, 1'b0, 4'd0},
        {1'b1, EP_D, 4'd0, 1'b1, 4'd4},
        {1'b1, EP_A, 4'd0, 1'b1, 4'd9}    // R4 set 5 untouched
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic train(input logic [15:0] ep, input logic [3:0] d);
        tr_vld = 1'b1; tr_ep = ep; tr_depth = d;
        cyc();
        tr_vld = 1'b0;
    endtask

    task automatic lookup(input logic [15:0] ep, input string req,
                          input bit eh, input int ed);
        lk_req = 1'b1; lk_ep = ep;
        cyc();
        lk_req = 1'b0;
        check("R1 rsp_vld", int'(lk_rsp_vld), 1);
        check({req, " hit"}, int'(lk_rsp_hit), int'(eh));
        check({req, " depth"}, int'(lk_rsp_depth), ed);
    endtask

    // lookup, then let the response start the trace
    task automatic begin_trace(input logic [15:0] ep, input int ed);
        lookup(ep, "R3", (ed != 15), ed);
        cyc();
    endtask

    task automatic mark(input int exp_redir, input string req);
        cp_mark = 1'b1;
        cyc();
        cp_mark = 1'b0;
        check(req, int'(redirect), exp_redir);
    endtask

    task automatic end_trace();
        trace_done = 1'b1;
        cyc();
        trace_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        // R11 reset state
        check("R11 rsp_vld", int'(lk_rsp_vld), 0);
        check("R11 redirect", int'(redirect), 0);
        check("R11 flush_busy", int'(flush_busy), 0);
        cyc();
        check("R1 no rsp without req", int'(lk_rsp_vld), 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][25]) lookup(VEC[i][24:9], VEC[i][4] ? "R3 R5" : "R2 R11",
                                   VEC[i][4], int'(VEC[i][3:0]));
            else            train(VEC[i][24:9], VEC[i][8:5]);
        end

        // R6 same-cycle train and lookup, same entry point
        tr_vld = 1'b1; tr_ep = 16'h0A30; tr_depth = 4'd6;
        lk_req = 1'b1; lk_ep = 16'h0A30;
        cyc();
        tr_vld = 1'b0; lk_req = 1'b0;
        check("R6 hit", int'(lk_rsp_hit), 1);
        check("R6 depth", int'(lk_rsp_depth), 6);
        cyc();

        // R7 depth 2 redirect, then R9 flush
        train(16'h0214, 4'd2);
        begin_trace(16'h0214, 2);
        check("R7 idle before marks", int'(redirect), 0);
        mark(0, "R7 first mark");
        mark(1, "R7 second mark");
        cyc();
        check("R7 single pulse", int'(redirect), 0);
        begin
            int busy = 0;
            fq_empty = 1'b1;
            for (int k = 0; k < 10; k++) begin
                cyc();
                fq_empty = 1'b0;
                if (flush_busy) busy++;
            end
            check("R9 flush cycles", busy, 5);
        end
        end_trace();

        // R10 rollback suppresses flush
        begin_trace(16'h0214, 2);
        mark(0, "R10 mark1");
        mark(1, "R10 mark2");
        rollback = 1'b1;
        cyc();
        rollback = 1'b0;
        begin
            int busy = 0;
            fq_empty = 1'b1;
            for (int k = 0; k < 8; k++) begin
                cyc();
                if (flush_busy) busy++;
            end
            fq_empty = 1'b0;
            check("R10 no flush", busy, 0);
        end

        // R8 full-depth prediction never redirects
        begin_trace(16'h0777, 15);
        begin
            int seen = 0;
            for (int k = 0; k < 15; k++) begin
                cp_mark = 1'b1;
                cyc();
                if (redirect) seen++;
            end
            cp_mark = 1'b0;
            check("R8 redirect count", seen, 0);
        end
        end_trace();

        // R7 depth 0 redirects right after the response
        train(16'h0215, 4'd0);
        lookup(16'h0215, "R3", 1'b1, 0);
        cyc();
        check("R7 depth zero redirect", int'(redirect), 1);
        rollback = 1'b1;
        cyc();
        rollback = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule